// File: doc/BRIEF.md
# Tag-Addressed Shared Memory Controller

This block sits between one load/store requester and a set of on-chip block RAMs, one RAM for each array. The requester issues 32-bit addresses that work like pointers. The top bits are a tag that picks the RAM. The bottom bits are an element index, which is passed unchanged to that RAM as its address. Each RAM can be narrower than the 32-bit data path. Stores keep only the low bits that fit. Loads come back zero-extended to 32 bits.

Two tag codes are reserved. Tag 0 stands for the null pointer. Tag 1 forwards the access to an off-chip memory through a request/acknowledge port, and the controller stalls until that port answers. An access to the null tag, an unmapped tag, or an index past a RAM's depth is rejected. A rejected access raises an error strobe, writes nothing, and a rejected load returns zero.

Load data from the on-chip RAMs appears one cycle after the request is accepted. The controller chooses which RAM output to return using a copy of the tag held in a register for that one cycle, so the choice lines up with the RAM read latency.

Top module: `tagmem_router`

## Requirements
- R1: An address is split into a tag in bits 31:23 (9 bits) and an index in bits 22:0 (23 bits). A request is accepted in any cycle where `req_valid` and `req_ready` are both high.
- R2: An accepted access with tag 0 raises `err_strobe` for one cycle, in the cycle after acceptance. It performs no write. If it is a load, `rsp_valid` is high in that same cycle with `rsp_rdata` equal to 0.
- R3: Tag 2+k selects RAM k, for k from 0 to NUM_RAMS-1. A store writes only that RAM, at the address given by the index, and produces no `rsp_valid`. A store to one RAM leaves the other RAMs unchanged at the same index.
- R4: An accepted on-chip load returns its data on `rsp_rdata`, with `rsp_valid` high, in the cycle after acceptance. The RAM output is chosen by the registered tag, so two loads to different RAMs in back-to-back cycles each return their own RAM's data.
- R5: An accepted access with a tag of NUM_RAMS+2 or higher (4 or higher with the default parameters) is unmapped. It behaves as in R2: error strobe, no write, and zero data for a load.
- R6: An accepted on-chip access with index DEPTH or higher (64 with the default parameters) raises `err_strobe`. It performs no write, including at the index taken modulo DEPTH, and a load returns 0.
- R7: RAM k is WIDE_W bits wide when k is even and NARROW_W bits wide when k is odd. With the defaults, tag 2 is 32 bits wide and tag 3 is 16 bits wide. A store to a narrow RAM keeps the low NARROW_W bits. Readback is zero-extended to 32 bits.
- R8: An accepted tag-1 access drives `ext_req` high from the next cycle onward. During that time `ext_addr` holds the index, `ext_write` holds the direction and `ext_wdata` holds the store data, all stable, and `req_ready` is low. The controller waits until `ext_ack` is high at a clock edge. In the cycle after that edge, `ext_req` is low and `req_ready` is high. For a load, `rsp_valid` is high in that cycle with `rsp_rdata` equal to the `ext_rdata` value seen at the acknowledge edge.
- R9: After reset, `req_ready` is high and `rsp_valid`, `err_strobe` and `ext_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 32 | Tag and index address |
| req_wdata | input | 32 | Store data |
| req_ready | output | 1 | Controller can accept a request |
| rsp_valid | output | 1 | Load data is valid |
| rsp_rdata | output | 32 | Load data, zero-extended |
| err_strobe | output | 1 | Rejected access (null tag, unmapped tag or index out of range) |
| ext_req | output | 1 | Off-chip request pending |
| ext_write | output | 1 | Off-chip direction |
| ext_addr | output | 23 | Off-chip index |
| ext_wdata | output | 32 | Off-chip store data |
| ext_ack | input | 1 | Off-chip access done |
| ext_rdata | input | 32 | Off-chip load data, sampled with the acknowledge |

## Verification
The assertions check the following on every cycle:
- the timing relations: a load gets its response one cycle after acceptance;
- a null access raises the error strobe and never reaches the off-chip port;
- the off-chip request holds its address until acknowledged;
- the controller is not ready while the off-chip request is pending;
- every error response carries zero data.

Only the bench scenarios can show the following data-dependent behaviour:
- that a store lands in the right RAM and nowhere else;
- that a rejected store leaves memory unchanged, including at the aliased index;
- that narrow RAMs truncate and zero-extend;
- that back-to-back loads to different RAMs each return the correct data.

// File: rtl/tagmem_router.sv
module tagmem_router #(
  parameter int NUM_RAMS = 2,
  parameter int DEPTH    = 64,
  parameter int WIDE_W   = 32,
  parameter int NARROW_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [31:0] req_addr,
  input  logic [31:0] req_wdata,
  output logic        req_ready,
  output logic        rsp_valid,
  output logic [31:0] rsp_rdata,
  output logic        err_strobe,
  output logic        ext_req,
  output logic        ext_write,
  output logic [22:0] ext_addr,
  output logic [31:0] ext_wdata,
  input  logic        ext_ack,
  input  logic [31:0] ext_rdata
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [8:0] NULL_TAG  = 9'd0;
  localparam logic [8:0] EXT_TAG   = 9'd1;
  localparam logic [8:0] FIRST_TAG = 9'd2;
  localparam logic [8:0] END_TAG   = 9'(NUM_RAMS + 2);

  logic [8:0]  tag;
  logic [22:0] idx;
  logic        acc, on_chip, bad, busy;
  logic [8:0]  tag_q;
  logic        rd_pend_q, err_q, err_ld_q, ext_rsp_q;
  logic [31:0] ext_data_q, ram_mux;
  logic [31:0] rq [NUM_RAMS];

  assign tag       = req_addr[31:23];
  assign idx       = req_addr[22:0];
  assign acc       = req_valid && req_ready;
  assign on_chip   = (tag >= FIRST_TAG) && (tag < END_TAG);
  assign bad       = (tag == NULL_TAG) || (tag >= END_TAG) ||
                     (on_chip && (idx >= 23'(DEPTH)));
  assign req_ready = !busy;
  assign ext_req   = busy;

  for (genvar k = 0; k < NUM_RAMS; k++) begin : g_ram
    localparam int W = (k % 2 == 0) ? WIDE_W : NARROW_W;
    logic [W-1:0] mem [DEPTH];
    logic [W-1:0] q;
    logic         sel;
    assign sel = acc && !bad && (tag == 9'(k + 2));
    always_ff @(posedge clk) begin
      if (sel && req_write) mem[idx[AW-1:0]] <= req_wdata[W-1:0];
      if (sel && !req_write) q <= mem[idx[AW-1:0]];
    end
    assign rq[k] = 32'(q);
  end

  always_comb begin
    ram_mux = '0;
    for (int k = 0; k < NUM_RAMS; k++)
      if (tag_q == 9'(k + 2)) ram_mux = rq[k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      tag_q      <= '0;
      rd_pend_q  <= 1'b0;
      err_q      <= 1'b0;
      err_ld_q   <= 1'b0;
      ext_rsp_q  <= 1'b0;
      ext_data_q <= '0;
      ext_write  <= 1'b0;
      ext_addr   <= '0;
      ext_wdata  <= '0;
    end else begin
      rd_pend_q <= acc && !bad && on_chip && !req_write;
      err_q     <= acc && bad;
      err_ld_q  <= acc && bad && !req_write;
      ext_rsp_q <= busy && ext_ack && !ext_write;
      if (acc) tag_q <= tag;
      if (busy && ext_ack) begin
        busy       <= 1'b0;
        ext_data_q <= ext_rdata;
      end else if (acc && tag == EXT_TAG) begin
        busy      <= 1'b1;
        ext_write <= req_write;
        ext_addr  <= idx;
        ext_wdata <= req_wdata;
      end
    end
  end

  assign rsp_valid  = rd_pend_q || err_ld_q || ext_rsp_q;
  assign err_strobe = err_q;
  assign rsp_rdata  = ext_rsp_q ? ext_data_q : (rd_pend_q ? ram_mux : 32'd0);

  assert_null_err_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && tag == NULL_TAG) |=> (err_strobe && !ext_req));
  assert_load_rsp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_write && tag != EXT_TAG) |=> rsp_valid);
  assert_err_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (err_strobe && rsp_valid) |-> (rsp_rdata == 32'd0));
  assert_ext_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ext_req |-> !req_ready);
  assert_ext_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_req && !ext_ack) |=> (ext_req && $stable(ext_addr) && $stable(ext_wdata)));
  assert_req_issue_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && tag == EXT_TAG) |=> (ext_req && ext_addr == $past(idx)));
endmodule

// File: tb/sim_tagmem_router.sv
`timescale 1ns/1ps
module sim_tagmem_router;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, ext_ack = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0, ext_rdata = '0;
  logic req_ready, rsp_valid, err_strobe, ext_req, ext_write;
  logic [31:0] rsp_rdata, ext_wdata;
  logic [22:0] ext_addr;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  tagmem_router u0 (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .err_strobe(err_strobe), .ext_req(ext_req), .ext_write(ext_write),
    .ext_addr(ext_addr), .ext_wdata(ext_wdata), .ext_ack(ext_ack), .ext_rdata(ext_rdata));

  function automatic logic [31:0] mk(input int t, input int i);
    return {9'(t), 23'(i)};
  endfunction

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // one accepted access; results sampled at the negedge after acceptance
  task automatic access(input logic wr, input logic [31:0] a, input logic [31:0] d,
                        output logic v, output logic e, output logic [31:0] q);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    v = rsp_valid; e = err_strobe; q = rsp_rdata;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 ready", 32'(req_ready), 32'd1);
    chk("R9 rsp_valid", 32'(rsp_valid), 32'd0);
    chk("R9 err", 32'(err_strobe), 32'd0);
    chk("R9 ext_req", 32'(ext_req), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_store_load;
    logic v, e; logic [31:0] q;
    access(1'b1, mk(2, 5), 32'hDEADBEEF, v, e, q);
    chk("R3 store no rsp", {30'd0, v, e}, 32'd0);
    access(1'b1, mk(2, 9), 32'h0BADF00D, v, e, q);
    access(1'b0, mk(2, 5), 32'h0, v, e, q);
    chk("R4 load valid", {30'd0, v, e}, 32'd2);
    chk("R1 R4 load data idx5", q, 32'hDEADBEEF);
    access(1'b0, mk(2, 9), 32'h0, v, e, q);
    chk("R1 R4 load data idx9", q, 32'h0BADF00D);
  endtask

  task automatic t_narrow;
    logic v, e; logic [31:0] q;
    access(1'b1, mk(3, 5), 32'h12345678, v, e, q);
    access(1'b0, mk(3, 5), 32'h0, v, e, q);
    chk("R7 narrow zext", q, 32'h00005678);
    access(1'b0, mk(2, 5), 32'h0, v, e, q);
    chk("R3 other ram untouched", q, 32'hDEADBEEF);
  endtask

  task automatic t_back2back;
    req_valid = 1'b1; req_write = 1'b0; req_addr = mk(2, 5);
    @(posedge clk); @(negedge clk);
    req_addr = mk(3, 5);
    chk("R4 b2b first valid", 32'(rsp_valid), 32'd1);
    chk("R4 b2b first data", rsp_rdata, 32'hDEADBEEF);
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    chk("R4 b2b second data", rsp_rdata, 32'h00005678);
    @(negedge clk);
    chk("R4 idle no rsp", 32'(rsp_valid), 32'd0);
  endtask

  task automatic t_null;
    logic v, e; logic [31:0] q;
    access(1'b1, mk(0, 5), 32'h11111111, v, e, q);
    chk("R2 null store err", {30'd0, v, e}, 32'd1);
    chk("R2 null no ext", 32'(ext_req), 32'd0);
    @(negedge clk);
    chk("R2 err one cycle", 32'(err_strobe), 32'd0);
    access(1'b0, mk(0, 5), 32'h0, v, e, q);
    chk("R2 null load flags", {30'd0, v, e}, 32'd3);
    chk("R2 null load zero", q, 32'd0);
  endtask

  task automatic t_unmapped;
    logic v, e; logic [31:0] q;
    access(1'b1, mk(4, 5), 32'h22222222, v, e, q);
    chk("R5 unmapped err", 32'(e), 32'd1);
    access(1'b0, mk(511, 5), 32'h0, v, e, q);
    chk("R5 unmapped load zero", {v, e, q[29:0]}, 32'hC0000000);
    access(1'b0, mk(2, 5), 32'h0, v, e, q);
    chk("R5 no write ram0", q, 32'hDEADBEEF);
    access(1'b0, mk(3, 5), 32'h0, v, e, q);
    chk("R5 no write ram1", q, 32'h00005678);
  endtask

  task automatic t_range;
    logic v, e; logic [31:0] q;
    access(1'b1, mk(2, 69), 32'hAAAAAAAA, v, e, q);
    chk("R6 range store err", 32'(e), 32'd1);
    access(1'b0, mk(2, 64), 32'h0, v, e, q);
    chk("R6 range load err", {30'd0, v, e}, 32'd3);
    chk("R6 range load zero", q, 32'd0);
    access(1'b0, mk(2, 5), 32'h0, v, e, q);
    chk("R6 alias untouched", q, 32'hDEADBEEF);
    access(1'b0, mk(2, 63), 32'h0, v, e, q);
    chk("R6 last index no err", 32'(e), 32'd0);
  endtask

  task automatic t_offchip;
    logic v, e; logic [31:0] q;
    access(1'b0, mk(1, 23'h7ABCDE), 32'h0, v, e, q);
    chk("R8 ext_req", 32'(ext_req), 32'd1);
    chk("R8 ext_addr", 32'(ext_addr), 32'h007ABCDE);
    chk("R8 ext_write", 32'(ext_write), 32'd0);
    chk("R8 stall", 32'(req_ready), 32'd0);
    chk("R8 no early rsp", 32'(rsp_valid), 32'd0);
    repeat (3) @(negedge clk);
    chk("R8 still waiting", {30'd0, ext_req, req_ready}, 32'd2);
    ext_ack = 1'b1; ext_rdata = 32'hCAFE0123;
    @(posedge clk); @(negedge clk);
    ext_ack = 1'b0; ext_rdata = '0;
    chk("R8 done flags", {29'd0, ext_req, req_ready, rsp_valid}, 32'd3);
    chk("R8 ext data", rsp_rdata, 32'hCAFE0123);
    access(1'b1, mk(1, 17), 32'h55AA55AA, v, e, q);
    chk("R8 ext store data", ext_wdata, 32'h55AA55AA);
    chk("R8 ext store dir", 32'(ext_write), 32'd1);
    ext_ack = 1'b1;
    @(posedge clk); @(negedge clk);
    ext_ack = 1'b0;
    chk("R8 store no rsp", {30'd0, rsp_valid, req_ready}, 32'd1);
  endtask

  initial begin
    fork
      begin
        @(negedge clk);
        t_reset; t_store_load; t_narrow; t_back2back;
        t_null; t_unmapped; t_range; t_offchip;
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule